// File: doc/BRIEF.md
# Streaming Adler-32 Checksum Engine

This block folds a byte stream into a 32-bit Adler-style checksum, accepting at most one byte per clock under a valid qualifier. A start pulse opens a new checksum, and a last flag closes it. When the message closes, the 32-bit result is loaded into a holding register and a one-cycle done strobe is raised. The block is used to seal or verify a stored image: the caller streams the covered region, from the generation field to the end of the image, and compares or stores the result. Counting bytes and generating addresses are left to the caller.

Two running sums of 16 bits are kept. The low sum starts at 1 and the high sum at 0. For every accepted byte, the byte is added to the low sum, and the new low sum is then added to the high sum. Both sums are reduced modulo 65521 on every byte. Each sum is always already below the modulus, so one compare and one subtraction complete the reduction and no divider is needed.

Top module: `adl_stream_sum`

## Requirements
- R1: After reset, done_o is 0 and sum_o reads 0x00000001.
- R2: A start pulse sets the low sum to 1 and the high sum to 0. A message with no bytes (start_i and last_i together, valid_i low) yields 0x00000001.
- R3: For each accepted byte, the low sum becomes (low + byte) mod 65521 first, and the high sum then becomes (high + new low) mod 65521.
- R4: Both running sums stay below 65521 at all times, including over long runs of 0xFF bytes that wrap the modulus many times.
- R5: The result puts the high sum in sum_o[31:16] and the low sum in sum_o[15:0].
- R6: A start pulse in the same cycle as a valid byte discards any partial message and begins a fresh checksum that includes that byte.
- R7: A last flag with valid_i high includes that final byte. done_o is high for exactly the one cycle after the clock edge that sampled last_i, and sum_o carries the result in that same cycle.
- R8: sum_o changes only in a cycle in which done_o is high, and it otherwise holds its value.
- R9: While no message is open, valid_i and last_i without start_i are ignored: done_o stays 0 and sum_o does not change.
- R10: Cycles with valid_i low inside a message leave the checksum unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a new checksum |
| valid_i | input | 1 | data_i holds a byte this cycle |
| data_i | input | 8 | Stream byte |
| last_i | input | 1 | Closes the message; includes this cycle's byte if valid_i is high |
| done_o | output | 1 | One-cycle strobe when the result is loaded |
| sum_o | output | 32 | Result register: high sum above low sum |

## Verification
The bench sends a stream of 5000 0xFF bytes. A reduction that fires late or subtracts the wrong amount lets a sum leave its range, and the result then differs from the reference. A restart is issued in the middle of an open message. A design that drops the byte arriving with start, or that keeps the old partial sums, produces a wrong checksum. The bench also sends the empty message, which exposes a wrong start value or a done strobe that never fires. It sends valid and last while no message is open, which catches a design that wrongly reacts to them. Random gaps in valid catch a design that updates the sums on idle cycles.

// File: rtl/adl_pkg.sv
package adl_pkg;
  localparam int unsigned ADL_MODULUS = 65521;
  localparam int          ADL_HALF_W  = 16;
  localparam int          ADL_BYTE_W  = 8;
endpackage

// File: rtl/adl_mod_add.sv
// Modular adder: y = (a + b) mod MODULUS, valid when a < MODULUS and b < MODULUS.
module adl_mod_add #(
  parameter int          W       = adl_pkg::ADL_HALF_W,
  parameter int          B_W     = adl_pkg::ADL_HALF_W,
  parameter int unsigned MODULUS = adl_pkg::ADL_MODULUS
) (
  input  logic [W-1:0]   a_i,
  input  logic [B_W-1:0] b_i,
  output logic [W-1:0]   y_o
);
  localparam int SW = W + 1;

  logic [SW-1:0] raw;
  logic [SW-1:0] reduced;
  logic          wrap;

  always_comb begin
    raw     = {1'b0, a_i} + SW'(b_i);
    reduced = raw - SW'(MODULUS);
    wrap    = (raw >= SW'(MODULUS));
    y_o     = wrap ? reduced[W-1:0] : raw[W-1:0];
  end
endmodule

// File: rtl/adl_ctrl.sv
// Message framing: tracks whether a message is open and raises done.
module adl_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic valid_i,
  input  logic last_i,
  output logic accept_o,
  output logic finish_o,
  output logic done_o
);
  logic open_q, open_d;
  logic done_q, done_d;
  logic live;

  always_comb begin
    live     = open_q | start_i;
    accept_o = live & valid_i;
    finish_o = live & last_i;
    if (finish_o)     open_d = 1'b0;
    else if (start_i) open_d = 1'b1;
    else              open_d = open_q;
    done_d = finish_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      open_q <= open_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  // R9: no message open and no start -> no done in the next cycle
  a_r9_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !start_i) |=> !done_o);
  // R7: done follows a sampled last of an open message
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (live && last_i) |=> done_o);
endmodule

// File: rtl/adl_sum_path.sv
// Running low/high sums with per-byte modular reduction.
module adl_sum_path #(
  parameter int          HALF_W  = adl_pkg::ADL_HALF_W,
  parameter int          BYTE_W  = adl_pkg::ADL_BYTE_W,
  parameter int unsigned MODULUS = adl_pkg::ADL_MODULUS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              accept_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [HALF_W-1:0] low_d_o,
  output logic [HALF_W-1:0] high_d_o
);
  logic [HALF_W-1:0] low_q, high_q;
  logic [HALF_W-1:0] low_base, high_base;
  logic [HALF_W-1:0] low_add, high_add;
  logic [HALF_W-1:0] low_d, high_d;
  logic              sum_en;

  always_comb begin
    low_base  = clear_i ? HALF_W'(1) : low_q;
    high_base = clear_i ? '0 : high_q;
  end

  adl_mod_add #(.W(HALF_W), .B_W(BYTE_W), .MODULUS(MODULUS)) i_low_add (
    .a_i(low_base), .b_i(byte_i), .y_o(low_add));

  adl_mod_add #(.W(HALF_W), .B_W(HALF_W), .MODULUS(MODULUS)) i_high_add (
    .a_i(high_base), .b_i(low_add), .y_o(high_add));

  always_comb begin
    low_d  = accept_i ? low_add  : low_base;
    high_d = accept_i ? high_add : high_base;
    sum_en = clear_i | accept_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= HALF_W'(1);
      high_q <= '0;
    end else if (sum_en) begin
      low_q  <= low_d;
      high_q <= high_d;
    end
  end

  assign low_d_o  = low_d;
  assign high_d_o = high_d;

  // R4: sums never reach the modulus
  a_r4_low_range: assert property (@(posedge clk) disable iff (!rst_n)
    low_q < HALF_W'(MODULUS));
  a_r4_high_range: assert property (@(posedge clk) disable iff (!rst_n)
    high_q < HALF_W'(MODULUS));
  // R2: a start without a byte leaves the initial sums
  a_r2_start_init: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !accept_i) |=> (low_q == HALF_W'(1) && high_q == '0));
  // R10: no byte and no start -> sums hold
  a_r10_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !accept_i) |=> ($stable(low_q) && $stable(high_q)));
endmodule

// File: rtl/adl_stream_sum.sv
module adl_stream_sum #(
  parameter int          HALF_W  = adl_pkg::ADL_HALF_W,
  parameter int          BYTE_W  = adl_pkg::ADL_BYTE_W,
  parameter int unsigned MODULUS = adl_pkg::ADL_MODULUS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                valid_i,
  input  logic [BYTE_W-1:0]   data_i,
  input  logic                last_i,
  output logic                done_o,
  output logic [2*HALF_W-1:0] sum_o
);
  localparam int RES_W = 2 * HALF_W;

  logic              accept, finish;
  logic [HALF_W-1:0] low_d, high_d;
  logic [RES_W-1:0]  res_q, res_d;

  adl_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
    .last_i(last_i), .accept_o(accept), .finish_o(finish), .done_o(done_o));

  adl_sum_path #(.HALF_W(HALF_W), .BYTE_W(BYTE_W), .MODULUS(MODULUS)) i_path (
    .clk(clk), .rst_n(rst_n), .clear_i(start_i), .accept_i(accept),
    .byte_i(data_i), .low_d_o(low_d), .high_d_o(high_d));

  always_comb res_d = {high_d, low_d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= RES_W'(1);
    else if (finish) res_q <= res_d;
  end

  assign sum_o = res_q;

  // R8: result moves only together with done
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(sum_o));
endmodule

// File: tb/test_adl_stream_sum.sv
module test_adl_stream_sum;
  localparam int CLK_PERIOD = 10;
  localparam int BUF_N      = 6000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, valid_i, last_i;
  logic [7:0]  data_i;
  logic        done_o;
  logic [31:0] sum_o;

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] buf_mem [BUF_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  adl_stream_sum i_adl_stream_sum (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
    .data_i(data_i), .last_i(last_i), .done_o(done_o), .sum_o(sum_o));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_sum(input int n);
    int unsigned lo = 1, hi = 0;
    for (int i = 0; i < n; i++) begin
      lo = (lo + buf_mem[i]) % 65521;
      hi = (hi + lo) % 65521;
    end
    return {hi[15:0], lo[15:0]};
  endfunction

  // Sends buf_mem[0..n-1] after a start cycle; called and returns at a negedge.
  task automatic run_msg(input int n, input int gap_pct, input string req);
    logic [31:0] exp;
    exp = ref_sum(n);
    start_i = 1'b1; valid_i = 1'b0; last_i = (n == 0);
    @(negedge clk);
    start_i = 1'b0; last_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      while (($urandom % 100) < gap_pct) begin
        valid_i = 1'b0;
        @(negedge clk);
      end
      valid_i = 1'b1; data_i = buf_mem[i]; last_i = (i == n - 1);
      @(negedge clk);
    end
    valid_i = 1'b0; last_i = 1'b0;
    chk(done_o === 1'b1, {req, " R7 done"}, {31'b0, done_o}, 32'd1);
    chk(sum_o === exp, req, sum_o, exp);
    @(negedge clk);
    chk(done_o === 1'b0, {req, " R7 done one cycle"}, {31'b0, done_o}, 32'd0);
    chk(sum_o === exp, {req, " R8 hold"}, sum_o, exp);
  endtask

  task automatic t_empty();
    run_msg(0, 0, "R2 empty message");
    chk(sum_o === 32'h1, "R2 empty value", sum_o, 32'h1);
  endtask

  task automatic t_known();
    buf_mem[0] = 8'h00;
    run_msg(1, 0, "R3 single zero byte");
    chk(sum_o === 32'h0001_0001, "R3 zero byte value", sum_o, 32'h0001_0001);
    buf_mem[0] = 8'h61; buf_mem[1] = 8'h62; buf_mem[2] = 8'h63;
    run_msg(3, 0, "R3 three bytes");
    chk(sum_o[31:16] === 16'h024D, "R5 high half", {16'b0, sum_o[31:16]}, 32'h024D);
    chk(sum_o[15:0] === 16'h0127, "R5 low half", {16'b0, sum_o[15:0]}, 32'h0127);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 5000; i++) buf_mem[i] = 8'hFF;
    run_msg(5000, 0, "R4 long 0xFF run");
  endtask

  task automatic t_random();
    for (int k = 0; k < 6; k++) begin
      int n;
      n = 1 + ($urandom % 300);
      for (int i = 0; i < n; i++) buf_mem[i] = 8'($urandom);
      run_msg(n, (k % 2) ? 40 : 0, (k % 2) ? "R10 random with gaps" : "R3 random dense");
    end
  endtask

  task automatic t_restart();
    logic [31:0] exp;
    int n;
    n = 20;
    for (int i = 0; i < n; i++) buf_mem[i] = 8'($urandom);
    exp = ref_sum(n);
    start_i = 1'b1; valid_i = 1'b1; data_i = 8'hA5; last_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 7; i++) begin
      data_i = 8'($urandom);
      @(negedge clk);
      chk(done_o === 1'b0, "R6 no done while open", {31'b0, done_o}, 32'd0);
    end
    start_i = 1'b1; valid_i = 1'b1; data_i = buf_mem[0];
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 1; i < n; i++) begin
      data_i = buf_mem[i]; last_i = (i == n - 1);
      @(negedge clk);
    end
    valid_i = 1'b0; last_i = 1'b0;
    chk(done_o === 1'b1, "R6 restart done", {31'b0, done_o}, 32'd1);
    chk(sum_o === exp, "R6 restart includes start byte", sum_o, exp);
    @(negedge clk);
  endtask

  task automatic t_idle();
    logic [31:0] held;
    held = sum_o;
    for (int i = 0; i < 4; i++) begin
      valid_i = 1'b1; data_i = 8'($urandom); last_i = (i % 2 == 1);
      @(negedge clk);
      chk(done_o === 1'b0, "R9 idle no done", {31'b0, done_o}, 32'd0);
      chk(sum_o === held, "R9 idle sum unchanged", sum_o, held);
    end
    valid_i = 1'b0; last_i = 1'b0;
    @(negedge clk);
    chk(sum_o === held, "R9 idle sum unchanged after", sum_o, held);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; valid_i = 1'b0; last_i = 1'b0; data_i = '0;
    repeat (3) @(negedge clk);
    chk(done_o === 1'b0, "R1 reset done", {31'b0, done_o}, 32'd0);
    chk(sum_o === 32'h1, "R1 reset sum", sum_o, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sum_o === 32'h1, "R1 sum after release", sum_o, 32'h1);
    t_empty();
    t_known();
    t_idle();
    t_wrap();
    t_random();
    t_restart();
    t_idle();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule